// File: doc/BRIEF.md
# Endpoint Configuration Header Register File

This block holds the sixteen dwords of a type 0 configuration header, the first 64 bytes of an endpoint function's configuration space. A configuration access port presents a dword index, a read or write strobe, four byte enables and write data. Every bit of every dword has its own access type: constant identification fields, plain read/write fields, sticky error flags that hardware sets and software clears by writing ones, and bits that are always zero.

The control word is driven out live so that the rest of the function can gate its IO decode, memory decode, bus mastering, error reporting and legacy interrupt. Single-cycle event inputs latch the error flags, a BIST completion input ends a self-test that software started, and the base address slots and the option ROM slot carry hardwired low bits, so that writing all ones and reading back shows the size and type of each window. Identification values, window sizes and window types are parameters.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset the control word (dword 1, bits [15:0]) reads 0, every sticky error flag reads 0, `intx_o` is 0, and every writable base, ROM and byte field reads 0.
- R2: Of the control word only bits 0, 1, 2, 6, 8 and 10 are writable; bits 3, 4, 5, 7, 9 and [15:11] always read 0, and `cmd_o` always equals the readable control word.
- R3: A write changes only the bytes whose byte enable is 1; a write-one-to-clear in a disabled byte clears nothing and a BIST start in a disabled byte starts nothing.
- R4: Status (dword 1, bits [31:16]) reads bit 20 as 1, bits [26:25] as 01b and bits 16, 17, 18, 21, 22 and 23 as 0.
- R5: A poisoned-data pulse sets bit 31 always and bit 24 only while control bit 6 is 1; a fatal-error pulse sets bit 30 only while control bit 8 is 1; the three abort pulses set bits 27 (abort sent), 28 (target abort received) and 29 (master abort received).
- R6: Each sticky flag stays set until a write with a 1 in its position clears it; writing 0 leaves it; an event in the same cycle as the clearing write leaves the flag set.
- R7: Status bit 19 reads the level of `intx_req`; `intx_o` follows `intx_req` only while control bit 10 is 0.
- R8: BIST byte (dword 3, bits [31:24]): bit 31 reads the capability parameter; writing 1 to bit 30 starts the test, which reads 1 until `bist_done`, when bit 30 clears and bits [27:24] take `bist_code`; writing 0 to bit 30 has no effect.
- R9: A base address slot (dwords 4 to 9) with size exponent L keeps bits [31:L] writable and reads its type code in bits [3:0] (bit 0 = 1 for IO, bit 3 = 1 for prefetchable); a slot with L = 0 reads 0 whatever is written.
- R10: The ROM slot (dword 12) keeps bit 0 and bits [31:L] writable with bits [L-1:1] reading 0; with no ROM it reads 0.
- R11: Byte 0 of dword 3 and byte 0 of dword 15 are read/write; byte 1 of dword 3 reads 0, byte 2 of dword 3 reads the multi-function flag in bit 23 with bits [22:16] zero, byte 1 of dword 15 reads the interrupt pin number (0 to 4); dwords 10 and 14 read 0.
- R12: Read data is returned with `cfg_rvalid` high in the cycle after the read strobe and reflects all writes that completed before that strobe.
- R13: Dwords 0, 2, 11 and 13 read the identification parameters (vendor/device, revision/class, subsystem vendor/device, capability pointer) and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idx | input | 4 | Dword index within the header |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| ev_poison | input | 1 | Poisoned data received |
| ev_fatal | input | 1 | Fatal error being reported |
| ev_sig_tabort | input | 1 | Completion with abort status sent |
| ev_rcv_tabort | input | 1 | Completion with abort status received |
| ev_rcv_mabort | input | 1 | Completion with unsupported status received |
| intx_req | input | 1 | Internal legacy interrupt level |
| bist_done | input | 1 | Self-test finished |
| bist_code | input | 4 | Self-test result, 0 for pass |
| cmd_o | output | 16 | Live control word |
| intx_o | output | 1 | Gated legacy interrupt |

## Verification
A write or an event pulse takes effect at the clock edge that samples it, so `cmd_o` and the state behind every dword are checked at the falling edge after that edge; a read strobe sampled at one edge returns its data registered at that edge, and the bench samples `cfg_rdata` and `cfg_rvalid` at the following falling edge. `intx_o` and status bit 19 are combinational from `intx_req` and the stored control bit, so they are checked in the same half cycle the level is driven. All stimulus changes on falling edges, and each check waits at least one full edge after the stimulus it depends on.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

   localparam int unsigned IDX_W = 4;

   localparam logic [IDX_W-1:0] IX_IDENT  = 4'd0;
   localparam logic [IDX_W-1:0] IX_CTLSTS = 4'd1;
   localparam logic [IDX_W-1:0] IX_CLASS  = 4'd2;
   localparam logic [IDX_W-1:0] IX_MISC   = 4'd3;
   localparam logic [IDX_W-1:0] IX_WIN0   = 4'd4;
   localparam logic [IDX_W-1:0] IX_SUBSYS = 4'd11;
   localparam logic [IDX_W-1:0] IX_ROM    = 4'd12;
   localparam logic [IDX_W-1:0] IX_CAPP   = 4'd13;
   localparam logic [IDX_W-1:0] IX_INTR   = 4'd15;

   localparam int unsigned NUM_WIN = 6;

   // writable control bits: io, mem, master, parity resp, serr, intx disable
   localparam logic [15:0] CTL_RW_MASK  = 16'h0547;
   // sticky flags within the status half-word
   localparam logic [15:0] STS_W1C_MASK = 16'hF900;
   // constant ones in status: capability list, medium select timing
   localparam logic [15:0] STS_CONST    = 16'h0210;

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m;
      for (int b = 0; b < 4; b++) begin
         m[8*b +: 8] = {8{be[b]}};
      end
      return m;
   endfunction

endpackage

// File: rtl/cfg_ctl_status.sv
module cfg_ctl_status
   import cfg_hdr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   input  logic        ev_poison,
   input  logic        ev_fatal,
   input  logic        ev_sig_tabort,
   input  logic        ev_rcv_tabort,
   input  logic        ev_rcv_mabort,
   input  logic        intx_req,
   output logic [15:0] ctl_o,
   output logic [15:0] sts_o,
   output logic        intx_o
);

   logic [15:0] ctl_q, ctl_d;
   logic [15:0] flg_q, flg_d;
   logic [15:0] flg_set, flg_clr;
   logic [31:0] lmask;

   always_comb begin
      lmask = lane_mask(be);
      ctl_d = ctl_q;
      if (wr_en) begin
         ctl_d = (ctl_q & ~(lmask[15:0] & CTL_RW_MASK))
               | (wdata[15:0] & lmask[15:0] & CTL_RW_MASK);
      end
   end

   always_comb begin
      flg_set     = '0;
      flg_set[15] = ev_poison;
      flg_set[14] = ev_fatal & ctl_q[8];
      flg_set[13] = ev_rcv_mabort;
      flg_set[12] = ev_rcv_tabort;
      flg_set[11] = ev_sig_tabort;
      flg_set[8]  = ev_poison & ctl_q[6];
      flg_clr     = wr_en ? (wdata[31:16] & lmask[31:16] & STS_W1C_MASK) : '0;
      flg_d       = (flg_q & ~flg_clr) | flg_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         flg_q <= '0;
      end else begin
         ctl_q <= ctl_d;
         flg_q <= flg_d & STS_W1C_MASK;
      end
   end

   assign ctl_o  = ctl_q;
   assign sts_o  = flg_q | STS_CONST | {12'd0, intx_req, 3'd0};
   assign intx_o = intx_req & ~ctl_q[10];

   // R5
   mdpe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_poison && !ctl_q[6] && !flg_q[8]) |=> !sts_o[8]);

   // R5
   mdpe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_poison && ctl_q[6]) |=> sts_o[8]);

   // R6
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be[3] && wdata[31] && !ev_poison) |=> !sts_o[15]);

   // R6
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q[15] && !(wr_en && be[3] && wdata[31])) |=> sts_o[15]);

   // R7
   intx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[10] |-> !intx_o);

endmodule

// File: rtl/cfg_selftest.sv
module cfg_selftest #(
   parameter bit CAPABLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_wr,
   input  logic       done,
   input  logic [3:0] code,
   output logic [7:0] byte_o
);

   generate
      if (CAPABLE) begin : g_cap
         logic       run_q;
         logic [3:0] code_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               run_q  <= 1'b0;
               code_q <= '0;
            end else if (done) begin
               run_q  <= 1'b0;
               code_q <= code;
            end else if (start_wr) begin
               run_q  <= 1'b1;
            end
         end

         assign byte_o = {1'b1, run_q, 2'b00, code_q};

         // R8
         bist_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && done) |=> !byte_o[6]);

         // R8
         bist_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (start_wr && !done) |=> byte_o[6]);
      end else begin : g_nocap
         logic unused_st;
         assign unused_st = ^{clk, rst_n, start_wr, done, code};
         assign byte_o    = '0;
      end
   endgenerate

endmodule

// File: rtl/cfg_win_slot.sv
module cfg_win_slot #(
   parameter int unsigned LOG2      = 12,
   parameter logic [31:0] LOW_CONST = 32'd0,
   parameter logic [31:0] EXTRA_RW  = 32'd0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [31:0] rdata
);

   generate
      if (LOG2 == 0) begin : g_absent
         logic unused_ws;
         assign unused_ws = ^{clk, rst_n, wr_en, be, wdata};
         assign rdata     = '0;
      end else begin : g_present
         localparam logic [31:0] WMASK = (32'hFFFF_FFFF << LOG2) | EXTRA_RW;
         logic [31:0] base_q;
         logic [31:0] lm;

         assign lm = cfg_hdr_pkg::lane_mask(be) & WMASK;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               base_q <= '0;
            end else if (wr_en) begin
               base_q <= (base_q & ~lm) | (wdata & lm);
            end
         end

         assign rdata = (base_q & WMASK) | LOW_CONST;

         // R9
         win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(rdata));
      end
   endgenerate

endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
   import cfg_hdr_pkg::*;
#(
   parameter logic [15:0]      VENDOR_ID  = 16'hC0DE,
   parameter logic [15:0]      DEVICE_ID  = 16'h5A17,
   parameter logic [7:0]       REV_ID     = 8'h03,
   parameter logic [23:0]      CLASS_CODE = 24'h020000,
   parameter logic [15:0]      SUBSYS_VID = 16'hC0DE,
   parameter logic [15:0]      SUBSYS_DID = 16'h0042,
   parameter logic [7:0]       CAP_PTR    = 8'h40,
   parameter logic [7:0]       INT_PIN    = 8'h01,
   parameter bit               MULTI_FN   = 1'b0,
   parameter bit               BIST_CAP   = 1'b1,
   parameter logic [5:0][4:0]  WIN_LOG2   = {5'd0, 5'd0, 5'd0, 5'd5, 5'd16, 5'd12},
   parameter logic [5:0][3:0]  WIN_TYPE   = {4'h0, 4'h0, 4'h0, 4'h1, 4'h8, 4'h0},
   parameter int unsigned      ROM_LOG2   = 14
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  cfg_idx,
   input  logic        cfg_wr,
   input  logic        cfg_rd,
   input  logic [3:0]  cfg_be,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   output logic        cfg_rvalid,
   input  logic        ev_poison,
   input  logic        ev_fatal,
   input  logic        ev_sig_tabort,
   input  logic        ev_rcv_tabort,
   input  logic        ev_rcv_mabort,
   input  logic        intx_req,
   input  logic        bist_done,
   input  logic [3:0]  bist_code,
   output logic [15:0] cmd_o,
   output logic        intx_o
);

   initial begin
      cap_align_chk: assert (CAP_PTR[1:0] == 2'b00 && CAP_PTR >= 8'h40)
         else $error("capability pointer must be dword aligned past the header");
      pin_range_chk: assert (INT_PIN <= 8'd4)
         else $error("interrupt pin out of range");
      rom_size_chk: assert (ROM_LOG2 == 0 || (ROM_LOG2 >= 11 && ROM_LOG2 <= 31))
         else $error("ROM size exponent out of range");
      for (int i = 0; i < NUM_WIN; i++) begin
         if (WIN_LOG2[i] != 0) begin
            if (WIN_TYPE[i][0]) begin
               io_win_chk: assert (WIN_LOG2[i] >= 2 && WIN_TYPE[i][3:1] == 3'b000)
                  else $error("IO window type or size invalid");
            end else begin
               mem_win_chk: assert (WIN_LOG2[i] >= 4 && WIN_TYPE[i][2:1] == 2'b00)
                  else $error("memory window type or size invalid");
            end
         end
      end
   end

   logic [15:0] sts_w;
   logic [7:0]  bist_w;
   logic [31:0] win_rd [NUM_WIN];
   logic [31:0] rom_rd;
   logic [7:0]  cls_q;
   logic [7:0]  irq_line_q;
   logic [31:0] rd_mux;
   logic [31:0] rdata_q;
   logic        rvalid_q;

   cfg_ctl_status u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (cfg_wr && cfg_idx == IX_CTLSTS),
      .be            (cfg_be),
      .wdata         (cfg_wdata),
      .ev_poison     (ev_poison),
      .ev_fatal      (ev_fatal),
      .ev_sig_tabort (ev_sig_tabort),
      .ev_rcv_tabort (ev_rcv_tabort),
      .ev_rcv_mabort (ev_rcv_mabort),
      .intx_req      (intx_req),
      .ctl_o         (cmd_o),
      .sts_o         (sts_w),
      .intx_o        (intx_o)
   );

   cfg_selftest #(.CAPABLE(BIST_CAP)) u_bist (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_wr (cfg_wr && cfg_idx == IX_MISC && cfg_be[3] && cfg_wdata[30]),
      .done     (bist_done),
      .code     (bist_code),
      .byte_o   (bist_w)
   );

   generate
      for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
         cfg_win_slot #(
            .LOG2      (int'(WIN_LOG2[i])),
            .LOW_CONST ({28'd0, WIN_TYPE[i]}),
            .EXTRA_RW  (32'd0)
         ) u_win (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (cfg_wr && cfg_idx == IX_WIN0 + 4'(i)),
            .be    (cfg_be),
            .wdata (cfg_wdata),
            .rdata (win_rd[i])
         );
      end
   endgenerate

   cfg_win_slot #(
      .LOG2      (ROM_LOG2),
      .LOW_CONST (32'd0),
      .EXTRA_RW  (32'd1)
   ) u_rom (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cfg_wr && cfg_idx == IX_ROM),
      .be    (cfg_be),
      .wdata (cfg_wdata),
      .rdata (rom_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cls_q      <= '0;
         irq_line_q <= '0;
      end else if (cfg_wr && cfg_be[0]) begin
         if (cfg_idx == IX_MISC) cls_q      <= cfg_wdata[7:0];
         if (cfg_idx == IX_INTR) irq_line_q <= cfg_wdata[7:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      case (cfg_idx)
         IX_IDENT:  rd_mux = {DEVICE_ID, VENDOR_ID};
         IX_CTLSTS: rd_mux = {sts_w, cmd_o};
         IX_CLASS:  rd_mux = {CLASS_CODE, REV_ID};
         IX_MISC:   rd_mux = {bist_w, MULTI_FN, 7'd0, 8'h00, cls_q};
         4'd4:      rd_mux = win_rd[0];
         4'd5:      rd_mux = win_rd[1];
         4'd6:      rd_mux = win_rd[2];
         4'd7:      rd_mux = win_rd[3];
         4'd8:      rd_mux = win_rd[4];
         4'd9:      rd_mux = win_rd[5];
         IX_SUBSYS: rd_mux = {SUBSYS_DID, SUBSYS_VID};
         IX_ROM:    rd_mux = rom_rd;
         IX_CAPP:   rd_mux = {24'd0, CAP_PTR};
         IX_INTR:   rd_mux = {16'd0, INT_PIN, irq_line_q};
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= cfg_rd;
         if (cfg_rd) rdata_q <= rd_mux;
      end
   end

   assign cfg_rdata  = rdata_q;
   assign cfg_rvalid = rvalid_q;

   // R12
   rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd |=> cfg_rvalid);

   // R12
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd |=> !cfg_rvalid);

   // R11
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_be[0] && cfg_idx == IX_INTR) |=> $stable(irq_line_q));

endmodule

// File: tb/cfg_hdr_regs_test.sv
module cfg_hdr_regs_test;

   localparam logic [15:0] VID  = 16'hC0DE;
   localparam logic [15:0] DID  = 16'h5A17;
   localparam logic [7:0]  REV  = 8'h03;
   localparam logic [23:0] CLS  = 24'h020000;
   localparam logic [15:0] SVID = 16'hC0DE;
   localparam logic [15:0] SDID = 16'h0042;
   localparam logic [7:0]  CAPP = 8'h40;
   localparam logic [7:0]  PIN  = 8'h01;
   localparam int          RLOG = 14;

   int          wl [6] = '{12, 16, 5, 0, 0, 0};
   logic [3:0]  wt [6] = '{4'h0, 4'h8, 4'h1, 4'h0, 4'h0, 4'h0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic        cfg_wr = 1'b0;
   logic        cfg_rd = 1'b0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        cfg_rvalid;
   logic        ev_poison = 1'b0, ev_fatal = 1'b0, ev_sig_tabort = 1'b0;
   logic        ev_rcv_tabort = 1'b0, ev_rcv_mabort = 1'b0;
   logic        intx_req = 1'b0, bist_done = 1'b0;
   logic [3:0]  bist_code = '0;
   logic [15:0] cmd_o;
   logic        intx_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   cfg_hdr_regs #(
      .VENDOR_ID(VID), .DEVICE_ID(DID), .REV_ID(REV), .CLASS_CODE(CLS),
      .SUBSYS_VID(SVID), .SUBSYS_DID(SDID), .CAP_PTR(CAPP), .INT_PIN(PIN),
      .MULTI_FN(1'b0), .BIST_CAP(1'b1),
      .WIN_LOG2({5'd0, 5'd0, 5'd0, 5'd5, 5'd16, 5'd12}),
      .WIN_TYPE({4'h0, 4'h0, 4'h0, 4'h1, 4'h8, 4'h0}),
      .ROM_LOG2(RLOG)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .cfg_rvalid(cfg_rvalid), .ev_poison(ev_poison), .ev_fatal(ev_fatal),
      .ev_sig_tabort(ev_sig_tabort), .ev_rcv_tabort(ev_rcv_tabort),
      .ev_rcv_mabort(ev_rcv_mabort), .intx_req(intx_req), .bist_done(bist_done),
      .bist_code(bist_code), .cmd_o(cmd_o), .intx_o(intx_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] lanes(input logic [3:0] be);
      logic [31:0] m;
      for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
      return m;
   endfunction

   function automatic logic [31:0] win_exp(input int l, input logic [3:0] t,
                                          input logic [31:0] extra, input logic [31:0] v);
      logic [31:0] wm;
      if (l == 0) return 32'd0;
      wm = (32'hFFFF_FFFF << l) | extra;
      return (v & wm) | {28'd0, t};
   endfunction

   task automatic wr(input logic [3:0] idx, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_idx = idx; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] idx, output logic [31:0] d);
      @(negedge clk);
      cfg_idx = idx; cfg_rd = 1'b1;
      @(negedge clk);
      cfg_rd = 1'b0;
      d = cfg_rdata;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: ev_poison = 1'b1;
         1: ev_fatal = 1'b1;
         2: ev_sig_tabort = 1'b1;
         3: ev_rcv_tabort = 1'b1;
         default: ev_rcv_mabort = 1'b1;
      endcase
      @(negedge clk);
      ev_poison = 1'b0; ev_fatal = 1'b0; ev_sig_tabort = 1'b0;
      ev_rcv_tabort = 1'b0; ev_rcv_mabort = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [15:0] cm;
      logic [31:0] exp;
      logic [31:0] pat;
      logic [31:0] wv [6];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state at the ports
      check("R1 cmd_o", {16'd0, cmd_o}, 32'd0);
      check("R1 intx_o", {31'd0, intx_o}, 32'd0);
      rd(4'd1, d); check("R1 R4 ctl/status", d, 32'h0210_0000);
      // R13 identification dwords
      rd(4'd0, d);  check("R13 ident", d, {DID, VID});
      rd(4'd2, d);  check("R13 class", d, {CLS, REV});
      rd(4'd11, d); check("R13 subsys", d, {SDID, SVID});
      rd(4'd13, d); check("R13 cap ptr", d, {24'd0, CAPP});
      // R11 R8 misc and interrupt dwords at reset
      rd(4'd3, d);  check("R11 R8 misc", d, 32'h8000_0000);
      rd(4'd15, d); check("R11 intr", d, {16'd0, PIN, 8'h00});
      for (int i = 0; i < 6; i++) begin
         rd(4'(4 + i), d); check("R1 R9 window reset", d, win_exp(wl[i], wt[i], 0, 0));
      end
      rd(4'd12, d); check("R1 R10 rom reset", d, 32'd0);

      // R12 response timing
      @(negedge clk);
      cfg_idx = 4'd0; cfg_rd = 1'b1;
      @(negedge clk);
      cfg_rd = 1'b0;
      check("R12 rvalid high", {31'd0, cfg_rvalid}, 32'd1);
      @(negedge clk);
      check("R12 rvalid low", {31'd0, cfg_rvalid}, 32'd0);

      // R2 R3 control word under every byte-enable pattern
      cm = '0;
      for (int p = 0; p < 3; p++) begin
         pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0000_0000 : 32'h0000_A5FA;
         for (int be = 0; be < 16; be++) begin
            exp = lanes(4'(be));
            cm = (cm & ~exp[15:0]) | (pat[15:0] & exp[15:0] & 16'h0547);
            wr(4'd1, 4'(be), pat);
            check("R2 cmd_o", {16'd0, cmd_o}, {16'd0, cm});
            rd(4'd1, d);
            check("R3 ctl bytes", {16'd0, d[15:0]}, {16'd0, cm});
         end
      end
      wr(4'd1, 4'b0011, 32'd0);

      // R5 event latching and gating
      pulse(0); rd(4'd1, d); check("R5 poison, parity resp off", {16'd0, d[31:16]}, 32'h8210);
      wr(4'd1, 4'b0011, 32'h0000_0040);
      pulse(0); rd(4'd1, d); check("R5 poison, parity resp on", {16'd0, d[31:16]}, 32'h8310);
      pulse(1); rd(4'd1, d); check("R5 fatal, serr off", {16'd0, d[31:16]}, 32'h8310);
      wr(4'd1, 4'b0011, 32'h0000_0140);
      pulse(1); rd(4'd1, d); check("R5 fatal, serr on", {16'd0, d[31:16]}, 32'hC310);
      pulse(2); pulse(3); pulse(4);
      rd(4'd1, d); check("R5 aborts", d, 32'hFB10_0140);

      // R6 write of zero keeps flags; R3 disabled lanes clear nothing
      wr(4'd1, 4'b1100, 32'h0000_0000);
      rd(4'd1, d); check("R6 write zero", d, 32'hFB10_0140);
      wr(4'd1, 4'b0011, 32'hFFFF_0000);
      rd(4'd1, d); check("R3 disabled w1c lanes", d, 32'hFB10_0000);
      wr(4'd1, 4'b1000, 32'h0800_0000);
      rd(4'd1, d); check("R6 clear one flag", {16'd0, d[31:16]}, 32'hF310);
      wr(4'd1, 4'b1100, 32'hFFFF_0000);
      rd(4'd1, d); check("R6 clear all", {16'd0, d[31:16]}, 32'h0210);

      // R6 event wins over a clearing write in the same cycle
      @(negedge clk);
      cfg_idx = 4'd1; cfg_be = 4'b1000; cfg_wdata = 32'h8000_0000; cfg_wr = 1'b1;
      ev_poison = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0; ev_poison = 1'b0;
      rd(4'd1, d); check("R6 set beats clear", {16'd0, d[31:16]}, 32'h8210);
      wr(4'd1, 4'b1000, 32'h8000_0000);

      // R7 legacy interrupt
      @(negedge clk); intx_req = 1'b1;
      #1 check("R7 intx passes", {31'd0, intx_o}, 32'd1);
      rd(4'd1, d); check("R7 status level", {16'd0, d[31:16]}, 32'h0218);
      wr(4'd1, 4'b0011, 32'h0000_0400);
      check("R7 intx masked", {31'd0, intx_o}, 32'd0);
      rd(4'd1, d); check("R7 status while masked", d, 32'h0218_0400);
      @(negedge clk); intx_req = 1'b0;
      rd(4'd1, d); check("R7 status drops", {16'd0, d[31:16]}, 32'h0210);

      // R8 self-test
      wr(4'd3, 4'b1000, 32'h0000_0000);
      rd(4'd3, d); check("R8 write zero no start", {24'd0, d[31:24]}, 32'h80);
      wr(4'd3, 4'b1000, 32'h4000_0000);
      rd(4'd3, d); check("R8 running", {24'd0, d[31:24]}, 32'hC0);
      @(negedge clk); bist_done = 1'b1; bist_code = 4'h5;
      @(negedge clk); bist_done = 1'b0; bist_code = 4'h0;
      rd(4'd3, d); check("R8 finished with code", {24'd0, d[31:24]}, 32'h85);
      wr(4'd3, 4'b0111, 32'h4000_0000);
      rd(4'd3, d); check("R3 R8 start lane disabled", {24'd0, d[31:24]}, 32'h85);

      // R9 window sizing, then partial writes
      for (int i = 0; i < 6; i++) begin
         wr(4'(4 + i), 4'hF, 32'hFFFF_FFFF);
         wv[i] = 32'hFFFF_FFFF;
         rd(4'(4 + i), d); check("R9 size probe", d, win_exp(wl[i], wt[i], 0, 32'hFFFF_FFFF));
      end
      for (int i = 0; i < 6; i++) begin
         exp = lanes(4'b0110);
         wv[i] = (wv[i] & ~exp) | (32'h1234_5678 & exp);
         wr(4'(4 + i), 4'b0110, 32'h1234_5678);
         rd(4'(4 + i), d); check("R9 R3 partial base", d, win_exp(wl[i], wt[i], 0, wv[i]));
      end

      // R10 ROM sizing and enable bit
      wr(4'd12, 4'hF, 32'hFFFF_FFFF);
      rd(4'd12, d); check("R10 rom probe", d, win_exp(RLOG, 4'h0, 32'd1, 32'hFFFF_FFFF));
      wr(4'd12, 4'b0001, 32'h0000_0000);
      rd(4'd12, d); check("R10 rom disable", d, win_exp(RLOG, 4'h0, 32'd1, 32'hFFFF_FF00));

      // R11 plain bytes and fixed bytes
      wr(4'd3, 4'b0111, 32'h00FF_AB10);
      rd(4'd3, d); check("R11 misc dword", d, 32'h8500_0010);
      wr(4'd15, 4'hF, 32'hFFFF_FFFF);
      rd(4'd15, d); check("R11 intr dword", d, {16'd0, PIN, 8'hFF});
      wr(4'd10, 4'hF, 32'hFFFF_FFFF);
      rd(4'd10, d); check("R11 dword 10", d, 32'd0);
      wr(4'd14, 4'hF, 32'hFFFF_FFFF);
      rd(4'd14, d); check("R11 dword 14", d, 32'd0);
      // R13 constants ignore writes
      wr(4'd0, 4'hF, 32'h0000_0000);
      rd(4'd0, d); check("R13 ident after write", d, {DID, VID});
      wr(4'd2, 4'hF, 32'hFFFF_FFFF);
      rd(4'd2, d); check("R13 class after write", d, {CLS, REV});

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule